// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and main memory and holds store data so that the processor can continue without waiting for each memory write to finish. It keeps a small number of entries. Each entry names one 32-byte block by its block address and carries up to four 64-bit words of that block, with one valid bit per word.

A store that targets a block already waiting in an entry is folded into that entry, so no new entry is used. The one exception is the entry being sent to memory at that moment: it is locked, and a store to its block opens a fresh entry. A store to any other block opens a new entry at the tail. Entries leave in arrival order through a request/acknowledge port. The oldest entry is offered with its block address, its data and its word mask, and the entry is freed when memory acknowledges it. When every entry is occupied and the incoming store cannot be folded in, the buffer raises a stall to the processor. The stall stays high until an entry is freed.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_req` is 0, and `wr_stall` is 0 while `wr_valid` is 0.
- R2: A store to a block not pending in any entry opens a new entry. When that entry is offered, `mem_mask` has only bit k set, where k is `wr_word`. Word k sits on `mem_data[64k+63:64k]`, and the words not written read as zero.
- R3: A store whose block matches an entry that is not being drained merges into that entry. It sets that word's mask bit and uses no extra entry, so the block is offered once with the combined mask.
- R4: A merge into a word that is already valid replaces the earlier data for that word.
- R5: Entries are offered to memory oldest first, in the order they were opened.
- R6: The entry being offered (`mem_req` high) is locked. A store to its block opens a new entry, which is offered after it with its own mask.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_blk`, `mem_mask` and `mem_data` hold steady. On an acknowledged cycle the entry is freed, and the next entry, if any, is offered in the following cycle.
- R8: With all four entries occupied, a store that cannot merge raises `wr_stall` in the same cycle and is not taken while the stall holds.
- R9: A store that can merge is taken without stall even when all entries are occupied.
- R10: In the cycle after an acknowledge frees an entry, a store that could not merge is accepted without stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store present this cycle |
| wr_blk | input | 29 | Block address of the store |
| wr_word | input | 2 | Word index within the block |
| wr_data | input | 64 | Store data |
| wr_stall | output | 1 | Store cannot be taken this cycle |
| mem_req | output | 1 | Oldest entry offered to memory |
| mem_blk | output | 29 | Block address of the offered entry |
| mem_mask | output | 4 | Valid words of the offered entry |
| mem_data | output | 256 | Four words of the offered entry, word k at bits 64k+63:64k |
| mem_ack | input | 1 | Memory takes the offered entry |

## Verification
Stores are sent as a lone store to a fresh block, as several stores to one waiting block (including a repeat to the same word), and as a store to the block being drained. Together these separate merging from allocation, show that the latest data wins, and show that the draining entry is locked. The buffer is filled with distinct blocks and offered a fifth block, then a mergeable store, then the fifth block again just after an acknowledge. This separates a full-buffer stall from a merge that must not stall and from stall release. A held request without acknowledge shows that the drain outputs stay stable, and the drain order across pointer wrap shows first-in, first-out service.

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int DEPTH  = 4,
  parameter int BLK_W  = 29,
  parameter int WORD_W = 64,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic [BLK_W-1:0]        wr_blk,
  input  logic [$clog2(WORDS)-1:0] wr_word,
  input  logic [WORD_W-1:0]       wr_data,
  output logic                    wr_stall,
  output logic                    mem_req,
  output logic [BLK_W-1:0]        mem_blk,
  output logic [WORDS-1:0]        mem_mask,
  output logic [WORDS*WORD_W-1:0] mem_data,
  input  logic                    mem_ack
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(WORDS);
  localparam int CNT_W = PTR_W + 1;

  logic [DEPTH-1:0]  ent_v;
  logic [BLK_W-1:0]  ent_blk  [DEPTH];
  logic [WORDS-1:0]  ent_mask [DEPTH];
  logic [WORD_W-1:0] ent_data [DEPTH][WORDS];
  logic [PTR_W-1:0]  head, tail, hit_idx;
  logic [CNT_W-1:0]  count;
  logic              hit, full, accept, alloc, merge, drain;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ent_v[i] && PTR_W'(i) != head && ent_blk[i] == wr_blk) begin
        hit = 1'b1;
        hit_idx = PTR_W'(i);
      end
  end

  assign full     = count == CNT_W'(DEPTH);
  assign wr_stall = wr_valid && !hit && full;
  assign accept   = wr_valid && !wr_stall;
  assign merge    = accept && hit;
  assign alloc    = accept && !hit;
  assign mem_req  = ent_v[head];
  assign drain    = mem_req && mem_ack;
  assign mem_blk  = ent_blk[head];
  assign mem_mask = mem_req ? ent_mask[head] : '0;

  always_comb
    for (int w = 0; w < WORDS; w++)
      mem_data[w*WORD_W +: WORD_W] = ent_data[head][w];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (drain) begin
        ent_v[head] <= 1'b0;
        head <= head + 1'b1;
      end
      if (alloc) begin
        ent_v[tail] <= 1'b1;
        tail <= tail + 1'b1;
      end
      count <= count + CNT_W'(alloc) - CNT_W'(drain);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      ent_blk[tail] <= wr_blk;
      for (int w = 0; w < WORDS; w++) begin
        ent_mask[tail][w] <= wr_word == OFF_W'(w);
        ent_data[tail][w] <= (wr_word == OFF_W'(w)) ? wr_data : '0;
      end
    end
    if (merge) begin
      ent_mask[hit_idx][wr_word] <= 1'b1;
      ent_data[hit_idx][wr_word] <= wr_data;
    end
  end
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk #(
  parameter int DEPTH  = 4,
  parameter int BLK_W  = 29,
  parameter int WORD_W = 64,
  parameter int WORDS  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_stall,
  input logic                    mem_req,
  input logic                    mem_ack,
  input logic [BLK_W-1:0]        mem_blk,
  input logic [WORDS-1:0]        mem_mask,
  input logic [WORDS*WORD_W-1:0] mem_data,
  input logic [$clog2(DEPTH):0]  count
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |-> !mem_req); // R1
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_mask != '0); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_blk) && $stable(mem_mask) && $stable(mem_data)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH)); // R8
  AST_STALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !wr_stall); // R10
endmodule

bind merge_wbuf merge_wbuf_chk #(.DEPTH(DEPTH), .BLK_W(BLK_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stall(wr_stall), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_blk(mem_blk), .mem_mask(mem_mask), .mem_data(mem_data), .count(count)
);

// File: tb/merge_wbuf_test.sv
module merge_wbuf_test;
  logic         clk = 0, rst_n = 0;
  logic         wr_valid = 0, mem_ack = 0;
  logic [28:0]  wr_blk = '0;
  logic [1:0]   wr_word = '0;
  logic [63:0]  wr_data = '0;
  logic         wr_stall, mem_req;
  logic [28:0]  mem_blk;
  logic [3:0]   mem_mask;
  logic [255:0] mem_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  merge_wbuf uut (.*);

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic [255:0] mk(input [63:0] d0, d1, d2, d3);
    return {d3, d2, d1, d0};
  endfunction

  task automatic put(input [28:0] b, input [1:0] w, input [63:0] d);
    wr_valid = 1; wr_blk = b; wr_word = w; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic take(input string tag, input [28:0] b, input [3:0] m, input [255:0] d);
    chk(mem_req && mem_blk == b && mem_mask == m && mem_data == d,
        $sformatf("%s drain req=%0b blk=%h mask=%b data=%h exp blk=%h mask=%b data=%h",
                  tag, mem_req, mem_blk, mem_mask, mem_data, b, m, d));
    mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
  endtask

  task automatic expect_empty(input string tag);
    chk(!mem_req, $sformatf("%s mem_req=%0b exp 0", tag, mem_req));
  endtask

  task automatic t_reset();
    chk(!mem_req && !wr_stall, $sformatf("R1 reset req=%0b stall=%0b exp 0 0", mem_req, wr_stall));
  endtask

  task automatic t_single();
    put(29'h0000A1, 2'd2, 64'h1111_2222_3333_4444);
    take("R2", 29'h0000A1, 4'b0100, mk(0, 0, 64'h1111_2222_3333_4444, 0));
    expect_empty("R2");
  endtask

  task automatic t_merge();
    put(29'h00A000, 2'd0, 64'hAAAA);
    put(29'h00B000, 2'd1, 64'hB1);
    put(29'h00B000, 2'd3, 64'hB3);
    put(29'h00B000, 2'd1, 64'hB1B1);
    take("R5 first", 29'h00A000, 4'b0001, mk(64'hAAAA, 0, 0, 0));
    take("R3 R4", 29'h00B000, 4'b1010, mk(0, 64'hB1B1, 0, 64'hB3));
    expect_empty("R3");
  endtask

  task automatic t_lock();
    put(29'h0C0C0C, 2'd0, 64'hC0);
    put(29'h0C0C0C, 2'd1, 64'hC1);
    take("R6 head", 29'h0C0C0C, 4'b0001, mk(64'hC0, 0, 0, 0));
    take("R6 new", 29'h0C0C0C, 4'b0010, mk(0, 64'hC1, 0, 0));
    expect_empty("R6");
  endtask

  task automatic t_hold();
    logic [28:0] b0; logic [3:0] m0; logic [255:0] d0;
    put(29'h0D0001, 2'd3, 64'hD3);
    b0 = mem_blk; m0 = mem_mask; d0 = mem_data;
    repeat (3) @(negedge clk);
    chk(mem_req && mem_blk == b0 && mem_mask == m0 && mem_data == d0,
        $sformatf("R7 hold req=%0b blk=%h mask=%b exp 1 %h %b", mem_req, mem_blk, mem_mask, b0, m0));
    take("R7", 29'h0D0001, 4'b1000, mk(0, 0, 0, 64'hD3));
    expect_empty("R7 freed");
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++) put(29'h100 + 29'(i), 2'd0, 64'hF0 + 64'(i));
    wr_valid = 1; wr_blk = 29'h104; wr_word = 2'd0; wr_data = 64'hF4;
    #1 chk(wr_stall, $sformatf("R8 stall=%0b exp 1", wr_stall));
    @(negedge clk);
    chk(wr_stall, $sformatf("R8 stall held=%0b exp 1", wr_stall));
    wr_blk = 29'h102; wr_word = 2'd1; wr_data = 64'hF21;
    #1 chk(!wr_stall, $sformatf("R9 merge stall=%0b exp 0", wr_stall));
    @(negedge clk);
    wr_valid = 0;
    take("R5 full", 29'h100, 4'b0001, mk(64'hF0, 0, 0, 0));
    wr_valid = 1; wr_blk = 29'h104; wr_word = 2'd0; wr_data = 64'hF4;
    #1 chk(!wr_stall, $sformatf("R10 stall=%0b exp 0", wr_stall));
    @(negedge clk);
    wr_valid = 0;
    take("R5 order", 29'h101, 4'b0001, mk(64'hF1, 0, 0, 0));
    take("R9 merged", 29'h102, 4'b0011, mk(64'hF2, 64'hF21, 0, 0));
    take("R5 order", 29'h103, 4'b0001, mk(64'hF3, 0, 0, 0));
    take("R8 R10 late", 29'h104, 4'b0001, mk(64'hF4, 0, 0, 0));
    expect_empty("R8 no extra");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_merge();
    t_lock();
    t_hold();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired, all requirements, actual hung exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule